// File: doc/BRIEF.md
# Conflict Victim Buffer

This block is a small, fully associative store that sits next to a direct-mapped cache and keeps the lines that the cache has recently thrown out. Every line the main cache evicts, clean or dirty, is offered on the insert port along with its full line address (tag and index) and its data. When a request misses in the main cache, the controller presents the line address on the lookup port before it sends anything to the next level. All entries are compared in parallel, and the hit indication and line data come back in the same cycle.

On a buffer hit, the line goes back into the main cache. The line that the main cache displaces to make room is written into the same entry in that cycle, so the two lines trade places. On a miss, the request goes on to the next level. When the buffer is full, a new insertion overwrites the oldest entry. If that entry is dirty, it leaves through a writeback port with a valid/ready handshake. In effect, the buffer gives a few extra ways to the sets that conflict most, and a pair of addresses that share an index can stop thrashing the cache.

Top module: `victim_buffer`

## Requirements
- R1: After reset, every entry is empty, `lookupHit` is 0 for any address, `wbValid` is 0 and `insReady` is 1.
- R2: While `lookupValid` is 1 and a valid entry holds exactly `lookupAddr`, `lookupHit` is 1 in the same cycle and `lookupData`/`lookupDirty` carry that entry's contents. `lookupHit` is 0 while `lookupValid` is 0.
- R3: An insertion is accepted when `insValid` and `insReady` are both 1 with no lookup hit in that cycle. It stores the address, data and dirty flag in the lowest-numbered empty entry whenever one exists, whatever the replacement pointer holds.
- R4: When all entries are valid, an insertion overwrites the entry at a rotating pointer. The pointer advances by one, wrapping at the entry count, on every accepted insertion. After an empty buffer fills, the first line inserted is the first one replaced.
- R5: When an insertion overwrites a dirty entry, that entry's address and data appear on `wbAddr`/`wbData` with `wbValid` 1 from the next cycle. They stay stable until `wbReady` is 1. An overwritten clean entry is dropped with no writeback.
- R6: `insReady` is 0 while a writeback is pending and `wbReady` is 0. An insertion offered then is ignored and changes no entry.
- R7: A lookup hit with `insValid` 1 in the same cycle is a swap. `lookupData` gives the old line, and the entry takes the offered address, data and dirty flag at the clock edge. A swap causes no writeback, leaves the pointer unchanged, and is accepted whatever `insReady` is.
- R8: A lookup hit with `insValid` 0 hands the line to the main cache and leaves its entry empty, so a repeat lookup of that address misses.
- R9: When a direct-mapped cache alternates accesses between two addresses that share an index, every access after the first two hits in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request after a main-cache miss |
| lookupAddr | input | LINE_ADDR_W | Line address (tag and index) being looked up |
| lookupHit | output | 1 | Lookup matched a valid entry (same cycle) |
| lookupData | output | LINE_DATA_W | Data of the matching entry |
| lookupDirty | output | 1 | Dirty flag of the matching entry |
| insValid | input | 1 | Evicted or displaced line offered |
| insReady | output | 1 | Insertion can be accepted this cycle |
| insAddr | input | LINE_ADDR_W | Line address of the offered line |
| insData | input | LINE_DATA_W | Data of the offered line |
| insDirty | input | 1 | Offered line is modified |
| wbValid | output | 1 | Dirty line pushed out, waiting for the next level |
| wbReady | input | 1 | Next level accepts the writeback |
| wbAddr | output | LINE_ADDR_W | Line address of the pushed-out line |
| wbData | output | LINE_DATA_W | Data of the pushed-out line |

## Verification
Four properties are checked on every cycle:
- a lookup never matches more than one entry;
- a stalled writeback holds its address and data;
- the writeback register is never reloaded while it is stalled;
- the count of valid entries moves in line with each operation: up by one on a fill, unchanged on a swap or a refused insertion, down by one when a hit frees its entry.

Three behaviours can only be shown by the bench's scenarios: which entry is chosen (lowest empty first, then oldest), what a swap or a hit leaves behind, and the steady hits under an alternating conflict pattern.

// File: rtl/vb_pkg.sv
package vb_pkg;

  // Strobes from the control to the entry datapath.
  typedef struct packed {
    logic wrEn;    // write the offered line into the selected entry
    logic clrEn;   // mark the selected entry empty
    logic wbLoad;  // copy the selected entry into the writeback register
  } vbCtrl_t;

endpackage

// File: rtl/vb_datapath.sv
module vb_datapath
  import vb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_ADDR_W = 26,
  parameter int LINE_DATA_W = 512,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vbCtrl_t                ctrl,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic                   lookupValid,
  input  logic [LINE_ADDR_W-1:0] lookupAddr,
  input  logic [LINE_ADDR_W-1:0] insAddr,
  input  logic [LINE_DATA_W-1:0] insData,
  input  logic                   insDirty,
  input  logic                   wbReady,
  output logic [NUM_ENTRIES-1:0] matchVec,
  output logic [NUM_ENTRIES-1:0] validVec,
  output logic [NUM_ENTRIES-1:0] dirtyVec,
  output logic [LINE_DATA_W-1:0] hitData,
  output logic                   hitDirty,
  output logic                   wbValid,
  output logic [LINE_ADDR_W-1:0] wbAddr,
  output logic [LINE_DATA_W-1:0] wbData
);

  logic                   validQ [NUM_ENTRIES];
  logic                   dirtyQ [NUM_ENTRIES];
  logic [LINE_ADDR_W-1:0] addrQ  [NUM_ENTRIES];
  logic [LINE_DATA_W-1:0] dataQ  [NUM_ENTRIES];

  logic                   wbValidQ;
  logic [LINE_ADDR_W-1:0] wbAddrQ;
  logic [LINE_DATA_W-1:0] wbDataQ;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    logic sel;
    assign sel = (wrIdx == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[e] <= 1'b0;
        dirtyQ[e] <= 1'b0;
      end else if (ctrl.wrEn && sel) begin
        validQ[e] <= 1'b1;
        dirtyQ[e] <= insDirty;
      end else if (ctrl.clrEn && sel) begin
        validQ[e] <= 1'b0;
        dirtyQ[e] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (ctrl.wrEn && sel) begin
        addrQ[e] <= insAddr;
        dataQ[e] <= insData;
      end
    end

    // Parallel tag compare: one comparator per entry.
    assign matchVec[e] = validQ[e] && (addrQ[e] == lookupAddr);
    assign validVec[e] = validQ[e];
    assign dirtyVec[e] = dirtyQ[e];
  end

  // At most one entry matches, so an OR of gated entries forms the mux.
  always_comb begin
    hitData  = '0;
    hitDirty = 1'b0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (matchVec[e]) begin
        hitData  = hitData | dataQ[e];
        hitDirty = hitDirty | dirtyQ[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValidQ <= 1'b0;
    end else if (ctrl.wbLoad) begin
      wbValidQ <= 1'b1;
    end else if (wbReady) begin
      wbValidQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.wbLoad) begin
      wbAddrQ <= addrQ[wrIdx];
      wbDataQ <= dataQ[wrIdx];
    end
  end

  assign wbValid = wbValidQ;
  assign wbAddr  = wbAddrQ;
  assign wbData  = wbDataQ;

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |-> $onehot0(matchVec));

  assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbAddr) && $stable(wbData)));

  assert_wb_no_clobber_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wbLoad |-> !(wbValidQ && !wbReady));

endmodule

// File: rtl/vb_control.sv
module vb_control
  import vb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic                   insValid,
  input  logic                   wbValid,
  input  logic                   wbReady,
  input  logic [NUM_ENTRIES-1:0] matchVec,
  input  logic [NUM_ENTRIES-1:0] validVec,
  input  logic [NUM_ENTRIES-1:0] dirtyVec,
  output vbCtrl_t                ctrl,
  output logic [IDX_W-1:0]       wrIdx,
  output logic                   lookupHit,
  output logic                   insReady
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] ptrQ;
  logic [IDX_W-1:0] hitIdx;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] victimIdx;
  logic             hasFree;
  logic             anyHit;
  logic             swapFire;
  logic             freeFire;
  logic             insFire;

  assign anyHit = lookupValid && (|matchVec);

  always_comb begin
    hitIdx = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      if (matchVec[e]) hitIdx = IDX_W'(e);
    end
  end

  // Lowest-numbered empty entry wins: scan from the top down.
  always_comb begin
    freeIdx = '0;
    hasFree = 1'b0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (!validVec[e]) begin
        freeIdx = IDX_W'(e);
        hasFree = 1'b1;
      end
    end
  end

  assign victimIdx = hasFree ? freeIdx : ptrQ;
  assign insReady  = !wbValid || wbReady;
  assign swapFire  = anyHit && insValid;
  assign freeFire  = anyHit && !insValid;
  assign insFire   = insValid && !anyHit && insReady;

  assign wrIdx       = anyHit ? hitIdx : victimIdx;
  assign ctrl.wrEn   = swapFire || insFire;
  assign ctrl.clrEn  = freeFire;
  assign ctrl.wbLoad = insFire && validVec[victimIdx] && dirtyVec[victimIdx];
  assign lookupHit   = anyHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (insFire) begin
      ptrQ <= (ptrQ == LAST_IDX) ? '0 : ptrQ + 1'b1;
    end
  end

  assert_fill_grows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (insFire && !(&validVec)) |=>
      ($countones(validVec) == $past($countones(validVec)) + 1));

  assert_swap_keeps_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    swapFire |=> ($countones(validVec) == $past($countones(validVec))));

  assert_hit_frees_R8: assert property (@(posedge clk) disable iff (!rstN)
    freeFire |=> ($countones(validVec) + 1 == $past($countones(validVec))));

  assert_stalled_insert_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !insReady && !anyHit) |=> $stable(validVec));

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vb_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_ADDR_W = 26,
  parameter int LINE_DATA_W = 512
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lookupValid,
  input  logic [LINE_ADDR_W-1:0] lookupAddr,
  output logic                   lookupHit,
  output logic [LINE_DATA_W-1:0] lookupData,
  output logic                   lookupDirty,
  input  logic                   insValid,
  output logic                   insReady,
  input  logic [LINE_ADDR_W-1:0] insAddr,
  input  logic [LINE_DATA_W-1:0] insData,
  input  logic                   insDirty,
  output logic                   wbValid,
  input  logic                   wbReady,
  output logic [LINE_ADDR_W-1:0] wbAddr,
  output logic [LINE_DATA_W-1:0] wbData
);

  localparam int IDX_W = $clog2(NUM_ENTRIES);

  initial begin
    assert (NUM_ENTRIES == 4 || NUM_ENTRIES == 8)
      else $error("victim_buffer: entry count must be 4 or 8");
  end

  vbCtrl_t                ctrl;
  logic [IDX_W-1:0]       wrIdx;
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [NUM_ENTRIES-1:0] validVec;
  logic [NUM_ENTRIES-1:0] dirtyVec;

  vb_control #(.NUM_ENTRIES(NUM_ENTRIES)) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .insValid    (insValid),
    .wbValid     (wbValid),
    .wbReady     (wbReady),
    .matchVec    (matchVec),
    .validVec    (validVec),
    .dirtyVec    (dirtyVec),
    .ctrl        (ctrl),
    .wrIdx       (wrIdx),
    .lookupHit   (lookupHit),
    .insReady    (insReady)
  );

  vb_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .LINE_ADDR_W (LINE_ADDR_W),
    .LINE_DATA_W (LINE_DATA_W)
  ) datapath_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .wrIdx       (wrIdx),
    .lookupValid (lookupValid),
    .lookupAddr  (lookupAddr),
    .insAddr     (insAddr),
    .insData     (insData),
    .insDirty    (insDirty),
    .wbReady     (wbReady),
    .matchVec    (matchVec),
    .validVec    (validVec),
    .dirtyVec    (dirtyVec),
    .hitData     (lookupData),
    .hitDirty    (lookupDirty),
    .wbValid     (wbValid),
    .wbAddr      (wbAddr),
    .wbData      (wbData)
  );

endmodule

// File: tb/victim_buffer_tb_top.sv
module victim_buffer_tb_top;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          lookupValid;
  logic [AW-1:0] lookupAddr;
  logic          lookupHit;
  logic [DW-1:0] lookupData;
  logic          lookupDirty;
  logic          insValid;
  logic          insReady;
  logic [AW-1:0] insAddr;
  logic [DW-1:0] insData;
  logic          insDirty;
  logic          wbValid;
  logic          wbReady;
  logic [AW-1:0] wbAddr;
  logic [DW-1:0] wbData;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  victim_buffer #(.NUM_ENTRIES(4), .LINE_ADDR_W(AW), .LINE_DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupHit(lookupHit), .lookupData(lookupData), .lookupDirty(lookupDirty),
    .insValid(insValid), .insReady(insReady),
    .insAddr(insAddr), .insData(insData), .insDirty(insDirty),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .wbData(wbData)
  );

  typedef struct packed {
    logic [15:0]   tag;
    logic          lv;
    logic [AW-1:0] la;
    logic          iv;
    logic [AW-1:0] ia;
    logic [DW-1:0] id;
    logic          idy;
    logic          wr;
    logic          eHit;
    logic [DW-1:0] eData;
    logic          eDirty;
    logic          eWbV;
    logic [AW-1:0] eWbA;
    logic [DW-1:0] eWbD;
    logic          eRdy;
  } vec_t;

  localparam int NV = 24;
  // tag, lookup(v,addr), insert(v,addr,data,dirty), wbReady | hit,data,dirty, wb(v,addr,data), insReady
  localparam vec_t VECS [NV] = '{
    '{"R2",1'b1,8'h11, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R3",1'b0,8'h00, 1'b1,8'h11,16'h1111,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R3",1'b0,8'h00, 1'b1,8'h22,16'h2222,1'b1, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R3",1'b0,8'h00, 1'b1,8'h33,16'h3333,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R3",1'b0,8'h00, 1'b1,8'h44,16'h4444,1'b1, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R2",1'b1,8'h33, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b1,16'h3333,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R8",1'b1,8'h33, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R3",1'b0,8'h00, 1'b1,8'h55,16'h5555,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R4",1'b0,8'h00, 1'b1,8'h66,16'h6666,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R5",1'b1,8'h22, 1'b0,8'h00,16'h0000,1'b0, 1'b0, 1'b0,16'h0000,1'b0, 1'b1,8'h22,16'h2222, 1'b0},
    '{"R6",1'b0,8'h00, 1'b1,8'h77,16'h7777,1'b0, 1'b0, 1'b0,16'h0000,1'b0, 1'b1,8'h22,16'h2222, 1'b0},
    '{"R6",1'b1,8'h77, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b1,8'h22,16'h2222, 1'b1},
    '{"R5",1'b0,8'h00, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R4",1'b0,8'h00, 1'b1,8'h77,16'h7777,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R5",1'b1,8'h55, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R7",1'b1,8'h44, 1'b1,8'h99,16'h9999,1'b1, 1'b1, 1'b1,16'h4444,1'b1, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R7",1'b1,8'h44, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R4",1'b0,8'h00, 1'b1,8'hAA,16'hAAAA,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R5",1'b1,8'h99, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b1,8'h99,16'h9999, 1'b1},
    '{"R2",1'b1,8'h66, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b1,16'h6666,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R8",1'b1,8'h66, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R3",1'b0,8'h00, 1'b1,8'hBB,16'hBBBB,1'b1, 1'b1, 1'b0,16'h0000,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R3",1'b1,8'h11, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b1,16'h1111,1'b0, 1'b0,8'h00,16'h0000, 1'b1},
    '{"R2",1'b1,8'hBB, 1'b0,8'h00,16'h0000,1'b0, 1'b1, 1'b1,16'hBBBB,1'b1, 1'b0,8'h00,16'h0000, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lookupValid = 1'b0; lookupAddr = '0;
    insValid = 1'b0; insAddr = '0; insData = '0; insDirty = 1'b0;
    wbReady = 1'b1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [DW-1:0] dataOf(input logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0;
    idle();
    doReset();

    // R1: reset state
    lookupValid = 1'b1; lookupAddr = 8'h11;
    #1;
    chk("R1", "hit after reset", 32'(lookupHit), 32'd0);
    chk("R1", "wbValid after reset", 32'(wbValid), 32'd0);
    chk("R1", "insReady after reset", 32'(insReady), 32'd1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      lookupValid = VECS[v].lv;  lookupAddr = VECS[v].la;
      insValid    = VECS[v].iv;  insAddr    = VECS[v].ia;
      insData     = VECS[v].id;  insDirty   = VECS[v].idy;
      wbReady     = VECS[v].wr;
      #1;
      chk($sformatf("%s", VECS[v].tag), $sformatf("v%0d hit", v),
          32'(lookupHit), 32'(VECS[v].eHit));
      if (VECS[v].eHit) begin
        chk($sformatf("%s", VECS[v].tag), $sformatf("v%0d data", v),
            32'(lookupData), 32'(VECS[v].eData));
        chk($sformatf("%s", VECS[v].tag), $sformatf("v%0d dirty", v),
            32'(lookupDirty), 32'(VECS[v].eDirty));
      end
      chk($sformatf("%s", VECS[v].tag), $sformatf("v%0d wbValid", v),
          32'(wbValid), 32'(VECS[v].eWbV));
      if (VECS[v].eWbV) begin
        chk($sformatf("%s", VECS[v].tag), $sformatf("v%0d wbAddr", v),
            32'(wbAddr), 32'(VECS[v].eWbA));
        chk($sformatf("%s", VECS[v].tag), $sformatf("v%0d wbData", v),
            32'(wbData), 32'(VECS[v].eWbD));
      end
      chk($sformatf("%s", VECS[v].tag), $sformatf("v%0d insReady", v),
          32'(insReady), 32'(VECS[v].eRdy));
    end

    // R1: reset in mid-run clears a line that was present (0x77)
    doReset();
    lookupValid = 1'b1; lookupAddr = 8'h77;
    #1;
    chk("R1", "hit after mid-run reset", 32'(lookupHit), 32'd0);
    chk("R1", "wbValid after mid-run reset", 32'(wbValid), 32'd0);

    // R9: alternating conflict pattern through a one-line direct-mapped model
    begin
      logic [AW-1:0] cacheAddr = '0;
      logic          cacheV    = 1'b0;
      for (int k = 0; k < 10; k++) begin
        logic [AW-1:0] a;
        a = (k % 2 == 0) ? 8'h05 : 8'h15;
        @(negedge clk);
        idle();
        lookupValid = 1'b1; lookupAddr = a;
        #1;
        if (k >= 2) begin
          chk("R9", $sformatf("access %0d hit", k), 32'(lookupHit), 32'd1);
          chk("R9", $sformatf("access %0d data", k), 32'(lookupData), 32'(dataOf(a)));
        end else begin
          chk("R9", $sformatf("access %0d miss", k), 32'(lookupHit), 32'd0);
        end
        if (lookupHit) begin
          insValid = 1'b1; insAddr = cacheAddr;
          insData = dataOf(cacheAddr); insDirty = 1'b0;
          @(posedge clk);
        end else begin
          @(posedge clk);
          @(negedge clk);
          lookupValid = 1'b0;
          if (cacheV) begin
            insValid = 1'b1; insAddr = cacheAddr;
            insData = dataOf(cacheAddr); insDirty = 1'b0;
          end
          @(posedge clk);
        end
        cacheAddr = a;
        cacheV    = 1'b1;
      end
      @(negedge clk);
      idle();
    end

    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

endmodule